// File: doc/BRIEF.md
# Halt Mode Release Controller

This block keeps track of whether the processor sits in one of three low-power halt modes and decides the cycle in which that state ends. The processor raises a one-cycle entry strobe together with a 2-bit mode code. While halted, the block watches a vector of interrupt request lines. Each line has a 3-bit priority level, and parameters mark each line as non-maskable, as a special wake line (keyboard, real-time clock or alarm) or as an asynchronous external pin. It compares each level against the processor's 3-bit mask level to decide whether halt ends and whether the interrupt is handed on for service.

The block also drives the clock enables for the halt period: one enable for the oscillator and one for each peripheral. A chip reset request always ends halt. When halt was the deepest (stop) mode, the block holds the processor for a programmable number of oscillator settling cycles before it signals the wake.

Top module: `halt_wake_ctrl`

## Requirements
- R1: After reset, halt_active, wake and svc_req are 0, osc_run is 1 and every periph_en bit is 1.
- R2: When not halted, halt_req with halt_mode 2'b01 (stop), 2'b10 (idle-1) or 2'b11 (idle-2) sets halt_active from the next cycle. halt_req with 2'b00 is ignored, and halt_active stays 0.
- R3: Clock enables are all 1 when not halted. In idle-2, osc_run is 1 and periph_en equals periph_keep. In idle-1, osc_run is 1 and periph_en is 0. In stop, both are 0.
- R4: While halted, a maskable request whose level is strictly greater than mask_lvl ends halt. One cycle after a synchronous request is presented, wake and svc_req pulse for one cycle with svc_id set to the source index, and halt_active is 0.
- R5: A maskable request whose level is less than or equal to mask_lvl does not end halt.
- R6: A non-maskable source ends halt and is serviced whatever its level and mask_lvl are.
- R7: A special wake source whose level is at or below mask_lvl ends halt with a wake pulse while svc_req stays 0. If its level is above the mask, it is serviced like any other maskable source.
- R8: When several serviceable requests are present, svc_id selects a non-maskable source first (the lowest index among them). Otherwise it selects the highest level, and on a tie the lowest index.
- R9: In stop mode, only the asynchronous sources can end halt, and all other lines are ignored. Asynchronous lines pass through two flops, so their wake appears three clock edges after the line rises.
- R10: reset_req during idle-1 or idle-2 ends halt with a wake pulse on the next cycle and no service.
- R11: reset_req during stop keeps halt_active high for stab_cycles+1 further cycles, with osc_run 1 and periph_en 0, and then pulses wake without service.
- R12: wake is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | One-cycle halt entry strobe |
| halt_mode | input | 2 | Halt mode code sampled with halt_req |
| mask_lvl | input | 3 | Processor interrupt mask level |
| irq_req | input | NUM_SRC (8) | Interrupt request lines |
| irq_lvl | input | NUM_SRC*LVL_W (24) | Packed levels, source i at bits [3i+2:3i] |
| periph_keep | input | NUM_PERIPH (4) | Peripherals kept clocked in idle-2 |
| stab_cycles | input | STAB_W (8) | Oscillator settling count after a stop reset |
| reset_req | input | 1 | Synchronous chip reset request |
| halt_active | output | 1 | Processor is held in halt |
| osc_run | output | 1 | Oscillator clock enable |
| periph_en | output | NUM_PERIPH (4) | Peripheral clock enables |
| wake | output | 1 | One-cycle pulse when halt ends |
| svc_req | output | 1 | Interrupt handed on for service, with wake |
| svc_id | output | 3 | Index of the serviced source |

## Verification
A corrupted state register shows up at the ports in the very next cycle. halt_active or the clock enables would disagree with the last mode entered, and a spurious or missing wake pulse would surface as an unmatched or leftover scoreboard entry. A wrong settling count appears only when the wake finally arrives, which can be up to stab_cycles+1 cycles after reset_req. For that reason the bench checks halt_active on every cycle of the wait rather than only at its end. A wrong arbitration shows as a svc_id mismatch on the wake cycle itself.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_STAB = 2'd2
  } hwc_state_e;

  localparam logic [1:0] HM_RSVD  = 2'b00;
  localparam logic [1:0] HM_STOP  = 2'b01;
  localparam logic [1:0] HM_IDLE1 = 2'b10;
  localparam logic [1:0] HM_IDLE2 = 2'b11;

  function automatic logic mode_usable(input logic [1:0] m);
    return m != HM_RSVD;
  endfunction

  function automatic logic level_beats(input logic [2:0] lvl, input logic [2:0] mask);
    return lvl > mask;
  endfunction
endpackage

// File: rtl/hwc_sync.sv
module hwc_sync #(
  parameter int NUM_SRC = 8,
  parameter logic [NUM_SRC-1:0] ASYNC_SRC = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_raw,
  output logic [NUM_SRC-1:0] req_s
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    if (ASYNC_SRC[g]) begin : g_async
      logic ff1_q, ff2_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ff1_q <= 1'b0;
          ff2_q <= 1'b0;
        end else begin
          ff1_q <= req_raw[g];
          ff2_q <= ff1_q;
        end
      end
      assign req_s[g] = ff2_q;
    end else begin : g_direct
      assign req_s[g] = req_raw[g];
    end
  end
endmodule

// File: rtl/hwc_release.sv
module hwc_release
  import hwc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int LVL_W = 3,
  parameter logic [NUM_SRC-1:0] ASYNC_SRC = '0,
  parameter logic [NUM_SRC-1:0] NMI_SRC = '0,
  parameter logic [NUM_SRC-1:0] SPECIAL_SRC = '0,
  localparam int IDW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SRC-1:0]         req_s,
  input  logic [NUM_SRC*LVL_W-1:0]   lvl_flat,
  input  logic [LVL_W-1:0]           mask,
  input  logic                       in_stop,
  output logic [NUM_SRC-1:0]         wake_vec,
  output logic [NUM_SRC-1:0]         svc_vec,
  output logic                       rel_any,
  output logic                       svc_any,
  output logic [IDW-1:0]             svc_pick
);
  logic [LVL_W-1:0] lvl_a [NUM_SRC];
  logic [NUM_SRC-1:0] live;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_qual
    logic above;
    assign lvl_a[g]    = lvl_flat[g*LVL_W +: LVL_W];
    assign live[g]     = req_s[g] & (!in_stop | ASYNC_SRC[g]);
    assign above       = lvl_a[g] > mask;
    assign svc_vec[g]  = live[g] & (NMI_SRC[g] | above);
    assign wake_vec[g] = svc_vec[g] | (live[g] & SPECIAL_SRC[g]);
  end

  assign rel_any = |wake_vec;
  assign svc_any = |svc_vec;

  logic             have_q, have_nmi;
  logic [LVL_W-1:0] best_lvl;

  always_comb begin
    have_q   = 1'b0;
    have_nmi = 1'b0;
    best_lvl = '0;
    svc_pick = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (svc_vec[i]) begin
        if (NMI_SRC[i]) begin
          if (!have_nmi) begin
            have_nmi = 1'b1;
            have_q   = 1'b1;
            svc_pick = IDW'(i);
          end
        end else if (!have_nmi && (!have_q || lvl_a[i] > best_lvl)) begin
          have_q   = 1'b1;
          best_lvl = lvl_a[i];
          svc_pick = IDW'(i);
        end
      end
    end
  end

  // R8: the picked source is always one that qualifies for service
  a_r8_pick_qualifies: assert property (@(posedge clk) disable iff (!rst_n)
    svc_any |-> svc_vec[svc_pick]);
  // R8: a pending non-maskable request always wins
  a_r8_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
    (|(svc_vec & NMI_SRC)) |-> NMI_SRC[svc_pick]);
  // R9: in stop, nothing outside the asynchronous set can release
  a_r9_stop_filter: assert property (@(posedge clk) disable iff (!rst_n)
    in_stop |-> ((wake_vec & ~ASYNC_SRC) == '0));
endmodule

// File: rtl/hwc_clkgate.sv
module hwc_clkgate
  import hwc_pkg::*;
#(
  parameter int NUM_PERIPH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  hwc_state_e            state,
  input  logic [1:0]            mode,
  input  logic [NUM_PERIPH-1:0] keep,
  output logic                  osc_run,
  output logic [NUM_PERIPH-1:0] periph_en
);
  always_comb begin
    osc_run   = 1'b1;
    periph_en = '1;
    case (state)
      ST_HALT: begin
        case (mode)
          HM_STOP: begin
            osc_run   = 1'b0;
            periph_en = '0;
          end
          HM_IDLE1: periph_en = '0;
          HM_IDLE2: periph_en = keep;
          default:  periph_en = '1;
        endcase
      end
      ST_STAB: periph_en = '0;
      default: ;
    endcase
  end

  // R3: stop halts every clock
  a_r3_stop_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT && mode == HM_STOP) |-> (!osc_run && periph_en == '0));
  // R11: the oscillator runs during the settling wait
  a_r11_stab_osc_on: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STAB) |-> (osc_run && periph_en == '0));
endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
  import hwc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int LVL_W = 3,
  parameter int NUM_PERIPH = 4,
  parameter int STAB_W = 8,
  parameter logic [NUM_SRC-1:0] ASYNC_SRC = 8'h07,
  parameter logic [NUM_SRC-1:0] NMI_SRC = 8'h08,
  parameter logic [NUM_SRC-1:0] SPECIAL_SRC = 8'hE0,
  localparam int IDW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     halt_req,
  input  logic [1:0]               halt_mode,
  input  logic [LVL_W-1:0]         mask_lvl,
  input  logic [NUM_SRC-1:0]       irq_req,
  input  logic [NUM_SRC*LVL_W-1:0] irq_lvl,
  input  logic [NUM_PERIPH-1:0]    periph_keep,
  input  logic [STAB_W-1:0]        stab_cycles,
  input  logic                     reset_req,
  output logic                     halt_active,
  output logic                     osc_run,
  output logic [NUM_PERIPH-1:0]    periph_en,
  output logic                     wake,
  output logic                     svc_req,
  output logic [IDW-1:0]           svc_id
);
  hwc_state_e       state_q;
  logic [1:0]       mode_q;
  logic [STAB_W-1:0] stab_cnt_q;
  logic             wake_q, svc_q;
  logic [IDW-1:0]   svc_id_q;

  logic [NUM_SRC-1:0] req_s, wake_vec, svc_vec;
  logic               rel_any, svc_any, in_stop;
  logic [IDW-1:0]     svc_pick;

  assign in_stop = (mode_q == HM_STOP);

  hwc_sync #(.NUM_SRC(NUM_SRC), .ASYNC_SRC(ASYNC_SRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .req_raw(irq_req), .req_s(req_s)
  );

  hwc_release #(
    .NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .ASYNC_SRC(ASYNC_SRC),
    .NMI_SRC(NMI_SRC), .SPECIAL_SRC(SPECIAL_SRC)
  ) u_release (
    .clk(clk), .rst_n(rst_n), .req_s(req_s), .lvl_flat(irq_lvl),
    .mask(mask_lvl), .in_stop(in_stop), .wake_vec(wake_vec),
    .svc_vec(svc_vec), .rel_any(rel_any), .svc_any(svc_any),
    .svc_pick(svc_pick)
  );

  hwc_clkgate #(.NUM_PERIPH(NUM_PERIPH)) u_clkgate (
    .clk(clk), .rst_n(rst_n), .state(state_q), .mode(mode_q),
    .keep(periph_keep), .osc_run(osc_run), .periph_en(periph_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_RUN;
      mode_q     <= HM_IDLE2;
      stab_cnt_q <= '0;
      wake_q     <= 1'b0;
      svc_q      <= 1'b0;
      svc_id_q   <= '0;
    end else begin
      wake_q <= 1'b0;
      svc_q  <= 1'b0;
      case (state_q)
        ST_RUN: begin
          if (halt_req && mode_usable(halt_mode)) begin
            state_q <= ST_HALT;
            mode_q  <= halt_mode;
          end
        end
        ST_HALT: begin
          if (reset_req) begin
            if (mode_q == HM_STOP) begin
              state_q    <= ST_STAB;
              stab_cnt_q <= stab_cycles;
            end else begin
              state_q <= ST_RUN;
              wake_q  <= 1'b1;
            end
          end else if (rel_any) begin
            state_q <= ST_RUN;
            wake_q  <= 1'b1;
            svc_q   <= svc_any;
            if (svc_any) svc_id_q <= svc_pick;
          end
        end
        ST_STAB: begin
          if (stab_cnt_q == '0) begin
            state_q <= ST_RUN;
            wake_q  <= 1'b1;
          end else begin
            stab_cnt_q <= stab_cnt_q - 1'b1;
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign halt_active = (state_q != ST_RUN);
  assign wake        = wake_q;
  assign svc_req     = svc_q;
  assign svc_id      = svc_id_q;

  // R2: the reserved code never enters halt
  a_r2_rsvd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && halt_req && halt_mode == HM_RSVD) |=> !halt_active);
  // R12: wake lasts one cycle
  a_r12_wake_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);
  // R7: service is only ever reported with a wake
  a_r7_svc_with_wake: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |-> wake);
  // R4: a wake means halt has ended
  a_r4_wake_ends_halt: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> !halt_active);
  // R5: with no release cause, halt persists
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALT && !rel_any && !reset_req) |=> (halt_active && !wake));
  // R11: the settling wait holds halt until the count is spent
  a_r11_stab_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STAB && stab_cnt_q != '0) |=> (halt_active && !wake));
endmodule

// File: tb/halt_wake_ctrl_bench.sv
module halt_wake_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       halt_req = 1'b0;
  logic [1:0] halt_mode = 2'b00;
  logic [2:0] mask_lvl = 3'd0;
  logic [7:0] irq_req = 8'h00;
  logic [23:0] irq_lvl = '0;
  logic [3:0] periph_keep = 4'b1010;
  logic [7:0] stab_cycles = 8'd5;
  logic       reset_req = 1'b0;
  logic       halt_active, osc_run, wake, svc_req;
  logic [3:0] periph_en;
  logic [2:0] svc_id;

  int compared = 0;
  int mismatched = 0;

  typedef struct {
    string tag;
    logic  svc;
    int    id;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  halt_wake_ctrl u_halt_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .halt_mode(halt_mode),
    .mask_lvl(mask_lvl), .irq_req(irq_req), .irq_lvl(irq_lvl),
    .periph_keep(periph_keep), .stab_cycles(stab_cycles), .reset_req(reset_req),
    .halt_active(halt_active), .osc_run(osc_run), .periph_en(periph_en),
    .wake(wake), .svc_req(svc_req), .svc_id(svc_id)
  );

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: every wake pulse must match the oldest expected item
  always @(negedge clk) begin
    if (rst_n && wake) begin
      if (exp_q.size() == 0) begin
        chk("R5/R9 unexpected wake", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk({e.tag, " svc_req"}, int'(svc_req), int'(e.svc));
        if (e.svc) chk({e.tag, " svc_id"}, int'(svc_id), e.id);
        chk({e.tag, " halt_active"}, int'(halt_active), 0);
      end
    end
  end

  task automatic push(input string tag, input logic svc, input int id);
    exp_t e;
    e.tag = tag; e.svc = svc; e.id = id;
    exp_q.push_back(e);
  endtask

  task automatic set_lvl(input int i, input logic [2:0] v);
    irq_lvl[i*3 +: 3] = v;
  endtask

  task automatic enter(input logic [1:0] m);
    @(negedge clk);
    halt_mode = m;
    halt_req  = 1'b1;
    @(negedge clk);
    halt_req = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    irq_req = 8'h00;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 halt_active", int'(halt_active), 0);
    chk("R1 osc_run", int'(osc_run), 1);
    chk("R1 periph_en", int'(periph_en), 15);
    chk("R1 wake", int'(wake), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reserved code ignored
    enter(2'b00);
    chk("R2 reserved no halt", int'(halt_active), 0);
    chk("R3 run clocks", int'(periph_en), 15);

    // R2/R3 idle-2, R5 then R4
    enter(2'b11);
    chk("R2 idle2 halted", int'(halt_active), 1);
    chk("R3 idle2 osc", int'(osc_run), 1);
    chk("R3 idle2 periph", int'(periph_en), 10);
    mask_lvl = 3'd3;
    set_lvl(4, 3'd3);
    irq_req[4] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5 level equal to mask holds", int'(halt_active), 1);
    set_lvl(4, 3'd2);
    repeat (2) @(negedge clk);
    chk("R5 level below mask holds", int'(halt_active), 1);
    push("R4 maskable release", 1'b1, 4);
    set_lvl(4, 3'd4);
    @(negedge clk);
    chk("R4 halt ended", int'(halt_active), 0);
    chk("R3 run after wake", int'(periph_en), 15);
    settle();

    // R3 idle-1, R6 non-maskable
    enter(2'b10);
    chk("R3 idle1 osc", int'(osc_run), 1);
    chk("R3 idle1 periph", int'(periph_en), 0);
    mask_lvl = 3'd7;
    set_lvl(3, 3'd0);
    push("R6 nmi release", 1'b1, 3);
    irq_req[3] = 1'b1;
    @(negedge clk);
    settle();

    // R7 special source below mask
    enter(2'b11);
    mask_lvl = 3'd5;
    set_lvl(6, 3'd1);
    push("R7 special masked", 1'b0, 0);
    irq_req[6] = 1'b1;
    @(negedge clk);
    settle();

    // R8 highest level
    enter(2'b11);
    mask_lvl = 3'd1;
    set_lvl(4, 3'd5); set_lvl(6, 3'd5); set_lvl(7, 3'd6);
    push("R8 highest level", 1'b1, 7);
    irq_req = 8'hD0;
    @(negedge clk);
    settle();

    // R8 tie goes to lowest index
    enter(2'b11);
    set_lvl(5, 3'd6); set_lvl(7, 3'd6);
    push("R8 tie lowest index", 1'b1, 5);
    irq_req = 8'hA0;
    @(negedge clk);
    settle();

    // R8 non-maskable first
    enter(2'b11);
    set_lvl(3, 3'd0); set_lvl(7, 3'd7);
    push("R8 nmi beats level", 1'b1, 3);
    irq_req = 8'h88;
    @(negedge clk);
    settle();

    // R9 stop: synchronous lines ignored, async line after two flops
    enter(2'b01);
    chk("R3 stop osc", int'(osc_run), 0);
    chk("R3 stop periph", int'(periph_en), 0);
    mask_lvl = 3'd0;
    set_lvl(4, 3'd7); set_lvl(3, 3'd0); set_lvl(6, 3'd7);
    irq_req = 8'h58;
    repeat (4) @(negedge clk);
    chk("R9 sync lines ignored in stop", int'(halt_active), 1);
    irq_req = 8'h00;
    @(negedge clk);
    set_lvl(1, 3'd2);
    push("R9 async release", 1'b1, 1);
    irq_req[1] = 1'b1;
    @(negedge clk);
    chk("R9 first flop stage", int'(halt_active), 1);
    @(negedge clk);
    chk("R9 second flop stage", int'(halt_active), 1);
    @(negedge clk);
    chk("R9 released on third edge", int'(halt_active), 0);
    settle();

    // R10 reset request in idle-1
    enter(2'b10);
    push("R10 reset in idle", 1'b0, 0);
    reset_req = 1'b1;
    @(negedge clk);
    reset_req = 1'b0;
    chk("R10 idle ended", int'(halt_active), 0);
    settle();

    // R11 reset request in stop with settling wait
    enter(2'b01);
    stab_cycles = 8'd5;
    reset_req = 1'b1;
    @(negedge clk);
    reset_req = 1'b0;
    for (int k = 0; k < 6; k++) begin
      chk("R11 held during wait", int'(halt_active), 1);
      chk("R11 osc on during wait", int'(osc_run), 1);
      chk("R11 periph off during wait", int'(periph_en), 0);
      if (k == 5) push("R11 wake after wait", 1'b0, 0);
      @(negedge clk);
    end
    chk("R11 released", int'(halt_active), 0);
    settle();

    // R11 zero-length wait
    enter(2'b01);
    stab_cycles = 8'd0;
    reset_req = 1'b1;
    @(negedge clk);
    reset_req = 1'b0;
    chk("R11 zero wait held", int'(halt_active), 1);
    push("R11 zero wait wake", 1'b0, 0);
    @(negedge clk);
    chk("R12 wake single cycle", int'(wake), 1);
    @(negedge clk);
    chk("R12 wake dropped", int'(wake), 0);
    settle();

    chk("R4 no pending expectations", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule